// File: doc/BRIEF.md
# Instruction Fetch Translation Fault Unit

This block sits in the instruction-fetch path next to the translation lookaside array. Each cycle that a fetch request is presented, it classifies the fetch address against four checks in a fixed order: whether the address is canonical, whether a superpage address is used outside kernel mode, whether the lookup missed, and whether the hit entry allows reading in the current privilege mode. It returns either a physical address or a fault class together with the trap vector that the core should vector to.

When a fault is found on a fetch that is not on a misspeculated path, the unit records the faulting PC in a fault tag register. It also records a formatted page-table-entry address, built by ORing the instruction page-table base with the virtual page number shifted left by three, so that the fault handler can load the missing entry directly. Misspeculated fetches and clean translations leave both registers untouched. The lookup array itself lives outside this block; only its hit flag, permission bits and page frame number come in.

Top module: `itrans_fault_unit`

## Requirements
- R1: An address whose bits 63..43 are not all equal to bit 42 is invalid and yields fault class 3 (access violation) with vector 0x0081, whatever the mode and lookup inputs.
- R2: A valid address with bits 42..41 equal to 2'b10 is a superpage address; in any mode other than kernel (mode code 0) it yields class 3 with vector 0x0081.
- R3: A superpage address in kernel mode yields class 0, vector 0 and a physical address equal to fetch address bits 43..0.
- R4: A valid, non-superpage address whose lookup misses yields class 1 (translation miss) with vector 0x0181.
- R5: On a lookup hit, if permission bit `lkup_perm[cur_mode]` is 0 (one read-enable bit per mode, bit 0 for kernel), the result is class 3 with vector 0x0081.
- R6: On a permitted hit the result is class 0, vector 0 and a physical address of the page frame number concatenated with fetch address bits 12..0; on any fault the physical address is 0.
- R7: On any fault with `spec_path` low, `fault_tag` becomes the fetch PC and `fault_form` becomes `ipt_base` ORed with fetch address bits 42..13 shifted left by 3.
- R8: A fetch with `spec_path` high, or one that does not fault, leaves `fault_tag` and `fault_form` unchanged.
- R9: Results appear on the outputs, with `out_valid` high, one clock edge after the request edge; a cycle without `req_valid` drops `out_valid` and holds the other result outputs.
- R10: Synchronous active-high reset clears every output, including the fault registers, to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fetch request present this cycle |
| fetch_pc | input | 64 | Virtual fetch address |
| spec_path | input | 1 | Fetch is on a misspeculated path |
| cur_mode | input | 2 | Current privilege mode, 0 = kernel |
| lkup_hit | input | 1 | Lookup array hit |
| lkup_perm | input | 4 | Read-enable bit per mode from the hit entry |
| lkup_pfn | input | 31 | Page frame number from the hit entry |
| ipt_base | input | 64 | Instruction page-table base register value |
| out_valid | output | 1 | Result outputs are new this cycle |
| phys_addr | output | 44 | Translated physical address, 0 on fault |
| fault_class | output | 2 | 0 none, 1 miss, 3 access violation |
| fault_vec | output | 16 | Trap vector, 0 when no fault |
| fault_tag | output | 64 | Last recorded faulting PC |
| fault_form | output | 64 | Last recorded formatted entry address |

## Verification
Every result of this block, the physical address, fault class, vector and both fault registers, is due exactly one clock edge after the edge that sampled the request, since each passes through one register stage. The bench drives a request on a falling edge, lets one rising edge pass, and reads all outputs on the following falling edge, so each check lands on the cycle its result is due. An idle cycle follows to confirm that `out_valid` drops while the other outputs hold, and a reset issued mid-run confirms that the fault registers return to zero on the next edge.

// File: rtl/itfu_pkg.sv
package itfu_pkg;

  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_MISS = 2'd1,
    FC_RSVD = 2'd2,
    FC_ACV  = 2'd3
  } fault_cls_e;

endpackage

// File: rtl/itfu_classify.sv
module itfu_classify
  import itfu_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int VA_IMPL    = 43,
  parameter int PA_W       = 44,
  parameter int PAGE_SHIFT = 13,
  parameter int MODE_W     = 2
) (
  input  logic [VA_W-1:0]             pc,
  input  logic                        hit,
  input  logic [(1<<MODE_W)-1:0]      perm,
  input  logic [PA_W-PAGE_SHIFT-1:0]  pfn,
  input  logic [MODE_W-1:0]           mode,
  output fault_cls_e                  cls,
  output logic [PA_W-1:0]             pa
);

  localparam int EXT_W = VA_W - VA_IMPL + 1;

  logic [EXT_W-1:0] ext_bits;
  logic             addr_ok;
  logic             in_super;
  logic             is_kernel;
  logic             mode_ok;
  logic [PA_W-1:0]  pa_super;
  logic [PA_W-1:0]  pa_mapped;

  assign ext_bits  = pc[VA_W-1:VA_IMPL-1];
  assign addr_ok   = (&ext_bits) | ~(|ext_bits);
  assign in_super  = (pc[VA_IMPL-1:VA_IMPL-2] == 2'b10);
  assign is_kernel = (mode == '0);
  assign mode_ok   = perm[mode];
  assign pa_super  = pc[PA_W-1:0];
  assign pa_mapped = {pfn, pc[PAGE_SHIFT-1:0]};

  // Fixed priority: bad address, superpage outside kernel, miss, permission.
  always_comb begin
    cls = FC_NONE;
    pa  = '0;
    if (!addr_ok) begin
      cls = FC_ACV;
    end else if (in_super) begin
      if (is_kernel) pa  = pa_super;
      else           cls = FC_ACV;
    end else if (!hit) begin
      cls = FC_MISS;
    end else if (!mode_ok) begin
      cls = FC_ACV;
    end else begin
      pa = pa_mapped;
    end
  end

  // The classifier never produces the reserved code.
  always_comb begin
    p_no_rsvd_r4: assert (cls != FC_RSVD);
  end

endmodule

// File: rtl/itfu_fault_regs.sv
module itfu_fault_regs #(
  parameter int VA_W       = 64,
  parameter int VA_IMPL    = 43,
  parameter int PAGE_SHIFT = 13,
  parameter int REG_W      = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [VA_W-1:0]  pc,
  input  logic [REG_W-1:0] base,
  output logic [REG_W-1:0] tag_q,
  output logic [REG_W-1:0] form_q
);

  localparam int VPN_W = VA_IMPL - PAGE_SHIFT;

  logic [VPN_W-1:0] vpn;
  logic [REG_W-1:0] vpn_field;

  assign vpn       = pc[VA_IMPL-1:PAGE_SHIFT];
  assign vpn_field = REG_W'({vpn, 3'b000});

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q  <= '0;
      form_q <= '0;
    end else if (wr_en) begin
      tag_q  <= REG_W'(pc);
      form_q <= base | vpn_field;
    end
  end

  p_tag_load_r7: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && !rst) |-> (tag_q == REG_W'($past(pc))));

  p_form_load_r7: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && !rst) |->
      (form_q[2:0] == $past(base[2:0])) &&
      (form_q[PAGE_SHIFT+2:3] == ($past(base[PAGE_SHIFT+2:3]) | $past(pc[PAGE_SHIFT+PAGE_SHIFT-1:PAGE_SHIFT]))));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> ($stable(tag_q) && $stable(form_q)));

endmodule

// File: rtl/itrans_fault_unit.sv
module itrans_fault_unit
  import itfu_pkg::*;
#(
  parameter int          VA_W       = 64,
  parameter int          VA_IMPL    = 43,
  parameter int          PA_W       = 44,
  parameter int          PAGE_SHIFT = 13,
  parameter int          MODE_W     = 2,
  parameter int          VEC_W      = 16,
  parameter logic [15:0] VEC_MISS   = 16'h0181,
  parameter logic [15:0] VEC_ACV    = 16'h0081
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  input  logic [VA_W-1:0]              fetch_pc,
  input  logic                         spec_path,
  input  logic [MODE_W-1:0]            cur_mode,
  input  logic                         lkup_hit,
  input  logic [(1<<MODE_W)-1:0]       lkup_perm,
  input  logic [PA_W-PAGE_SHIFT-1:0]   lkup_pfn,
  input  logic [VA_W-1:0]              ipt_base,
  output logic                         out_valid,
  output logic [PA_W-1:0]              phys_addr,
  output logic [1:0]                   fault_class,
  output logic [VEC_W-1:0]             fault_vec,
  output logic [VA_W-1:0]              fault_tag,
  output logic [VA_W-1:0]              fault_form
);

  fault_cls_e       cls_c;
  logic [PA_W-1:0]  pa_c;
  logic [VEC_W-1:0] vec_c;
  logic             log_fault;

  itfu_classify #(
    .VA_W(VA_W), .VA_IMPL(VA_IMPL), .PA_W(PA_W),
    .PAGE_SHIFT(PAGE_SHIFT), .MODE_W(MODE_W)
  ) u_classify (
    .pc(fetch_pc), .hit(lkup_hit), .perm(lkup_perm), .pfn(lkup_pfn),
    .mode(cur_mode), .cls(cls_c), .pa(pa_c)
  );

  always_comb begin
    unique case (cls_c)
      FC_MISS: vec_c = VEC_W'(VEC_MISS);
      FC_ACV:  vec_c = VEC_W'(VEC_ACV);
      default: vec_c = '0;
    endcase
  end

  assign log_fault = req_valid && (cls_c != FC_NONE) && !spec_path;

  itfu_fault_regs #(
    .VA_W(VA_W), .VA_IMPL(VA_IMPL), .PAGE_SHIFT(PAGE_SHIFT), .REG_W(VA_W)
  ) u_fregs (
    .clk(clk), .rst(rst), .wr_en(log_fault), .pc(fetch_pc),
    .base(ipt_base), .tag_q(fault_tag), .form_q(fault_form)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      phys_addr   <= '0;
      fault_class <= '0;
      fault_vec   <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        phys_addr   <= pa_c;
        fault_class <= cls_c;
        fault_vec   <= vec_c;
      end
    end
  end

  // Independent re-derivation of the address checks from the ports.
  p_bad_va_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(!((&fetch_pc[VA_W-1:VA_IMPL-1]) || !(|fetch_pc[VA_W-1:VA_IMPL-1])))
      |-> (fault_class == 2'd3));

  p_super_user_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past((&fetch_pc[VA_W-1:VA_IMPL-1]) && (fetch_pc[VA_IMPL-2] == 1'b0) && (cur_mode != '0))
      |-> (fault_class == 2'd3));

  p_miss_vec_r4: assert property (@(posedge clk) disable iff (rst)
    (fault_class == 2'd1) |-> (fault_vec == VEC_W'(VEC_MISS)));

  p_clean_r6: assert property (@(posedge clk) disable iff (rst)
    (fault_class == 2'd0) |-> (fault_vec == '0));

  p_fault_pa_r6: assert property (@(posedge clk) disable iff (rst)
    (fault_class != 2'd0) |-> (phys_addr == '0));

  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(req_valid) |-> !out_valid);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    $past(!req_valid && !rst) |-> ($stable(phys_addr) && $stable(fault_class) && $stable(fault_vec)));

endmodule

// File: tb/itrans_fault_unit_test.sv
module itrans_fault_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  typedef struct packed {
    logic [63:0] pc;
    logic        hit;
    logic [3:0]  perm;
    logic [30:0] pfn;
    logic [1:0]  mode;
    logic        spec;
    logic [1:0]  cls;
  } vec_t;

  localparam logic [63:0] PC_BAD  = 64'h0001_0000_0000_4000;
  localparam logic [63:0] PC_SUP  = 64'hFFFF_FC00_0000_1ABC;
  localparam logic [63:0] PC_LOW  = 64'h0000_0000_1234_5678;
  localparam logic [63:0] PC_NEG  = 64'hFFFF_FE00_0000_2F0F;
  localparam logic [63:0] PC_BAD2 = 64'hFFFF_F000_0000_0000;

  localparam vec_t TBL [NV] = '{
    '{PC_BAD,  1'b1, 4'hF, 31'h11,   2'd0, 1'b0, 2'd3},
    '{PC_SUP,  1'b0, 4'h0, 31'h0,    2'd0, 1'b0, 2'd0},
    '{PC_SUP,  1'b1, 4'hF, 31'h5,    2'd2, 1'b0, 2'd3},
    '{PC_LOW,  1'b0, 4'hF, 31'h7,    2'd1, 1'b0, 2'd1},
    '{PC_LOW,  1'b1, 4'b0001, 31'h9, 2'd1, 1'b0, 2'd3},
    '{PC_LOW,  1'b1, 4'b0010, 31'h1234_567, 2'd1, 1'b0, 2'd0},
    '{PC_NEG,  1'b0, 4'hF, 31'h3,    2'd0, 1'b1, 2'd1},
    '{PC_BAD2, 1'b1, 4'hF, 31'h2,    2'd0, 1'b1, 2'd3},
    '{PC_SUP,  1'b1, 4'hF, 31'h4,    2'd3, 1'b0, 2'd3},
    '{PC_NEG,  1'b1, 4'b1000, 31'h7FFF_FFFF, 2'd3, 1'b0, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [63:0] fetch_pc;
  logic        spec_path;
  logic [1:0]  cur_mode;
  logic        lkup_hit;
  logic [3:0]  lkup_perm;
  logic [30:0] lkup_pfn;
  logic [63:0] ipt_base;
  logic        out_valid;
  logic [43:0] phys_addr;
  logic [1:0]  fault_class;
  logic [15:0] fault_vec;
  logic [63:0] fault_tag;
  logic [63:0] fault_form;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [63:0] exp_tag = '0;
  logic [63:0] exp_form = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  itrans_fault_unit uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .fetch_pc(fetch_pc),
    .spec_path(spec_path), .cur_mode(cur_mode), .lkup_hit(lkup_hit),
    .lkup_perm(lkup_perm), .lkup_pfn(lkup_pfn), .ipt_base(ipt_base),
    .out_valid(out_valid), .phys_addr(phys_addr), .fault_class(fault_class),
    .fault_vec(fault_vec), .fault_tag(fault_tag), .fault_form(fault_form)
  );

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic string cls_req(vec_t v);
    if (v.pc[63:42] != '0 && v.pc[63:42] != '1) return "R1";
    if (v.pc[42:41] == 2'b10) return (v.mode == 0) ? "R3" : "R2";
    if (!v.hit) return "R4";
    return v.cls == 2'd3 ? "R5" : "R6";
  endfunction

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; fetch_pc = '0; spec_path = 1'b0;
    cur_mode = '0; lkup_hit = 1'b0; lkup_perm = '0; lkup_pfn = '0;
    ipt_base = 64'h0000_0002_0000_0000;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "out_valid", 64'(out_valid), 0);
    chk("R10", "phys_addr", 64'(phys_addr), 0);
    chk("R10", "class", 64'(fault_class), 0);
    chk("R10", "vec", 64'(fault_vec), 0);
    chk("R10", "tag", fault_tag, 0);
    chk("R10", "form", fault_form, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [43:0] exp_pa;
      logic [15:0] exp_vec;
      string rq;
      vec_t v;
      v = TBL[i];
      rq = cls_req(v);
      @(negedge clk);
      req_valid = 1'b1; fetch_pc = v.pc; lkup_hit = v.hit; lkup_perm = v.perm;
      lkup_pfn = v.pfn; cur_mode = v.mode; spec_path = v.spec;
      ipt_base = ipt_base + 64'h1_0000_0000;
      exp_pa = '0;
      if (v.cls == 2'd0) exp_pa = (v.pc[42:41] == 2'b10) ? v.pc[43:0] : {v.pfn, v.pc[12:0]};
      exp_vec = (v.cls == 2'd1) ? 16'h0181 : (v.cls == 2'd3) ? 16'h0081 : 16'h0000;
      if (v.cls != 2'd0 && !v.spec) begin
        exp_tag = v.pc;
        exp_form = ipt_base | {31'b0, v.pc[42:13], 3'b000};
      end
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9", "out_valid", 64'(out_valid), 1);
      chk(rq, "class", 64'(fault_class), 64'(v.cls));
      chk(rq, "vec", 64'(fault_vec), 64'(exp_vec));
      chk("R6", "phys_addr", 64'(phys_addr), 64'(exp_pa));
      chk((v.cls != 2'd0 && !v.spec) ? "R7" : "R8", "tag", fault_tag, exp_tag);
      chk((v.cls != 2'd0 && !v.spec) ? "R7" : "R8", "form", fault_form, exp_form);
    end

    // R9: idle cycle drops out_valid, holds results
    @(negedge clk);
    chk("R9", "idle out_valid", 64'(out_valid), 0);
    chk("R9", "idle class hold", 64'(fault_class), 0);
    chk("R9", "idle pa hold", 64'(phys_addr), {20'b0, 31'h7FFF_FFFF, PC_NEG[12:0]});

    // R8: fault with spec high while idle inputs change leaves registers
    fetch_pc = PC_BAD; spec_path = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; spec_path = 1'b0;
    chk("R8", "spec tag", fault_tag, exp_tag);
    chk("R1", "spec class", 64'(fault_class), 3);

    // R10: reset mid-run clears fault registers
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10", "tag after reset", fault_tag, 0);
    chk("R10", "form after reset", fault_form, 0);
    chk("R10", "class after reset", 64'(fault_class), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule